// File: doc/BRIEF.md
# Pixel Word Unpacker and Display Bus Mapper

This block sits between a pixel FIFO that delivers 32-bit memory words and the parallel data pins of a display panel. Each word carries either two RGB565 pixels or one 24-bit RGB pixel whose top byte is unused. A per-byte valid mask zeroes unwanted bytes as the word is taken in. A pixel request strobe from the display timing logic pulls one pixel (or one byte beat on a narrow bus) out per request. The result is formatted for the selected bus width, with optional reduction of 24-bit colour to 18 bits by dropping the two least significant bits of each component.

Words are accepted with a valid/ready handshake. A word is taken only when no pixel of the previous word remains, or in the same cycle that the last one is consumed. A request that finds no pixel pending raises a one-cycle underflow pulse. Unsupported settings are flagged and block word intake.

Control is a four-state machine. `S_EMPTY` holds no pixel. `S_LO16` holds a 16-bit-pixel word whose lower half is pending. `S_HI16` has only the upper half pending. `S_WORD24` holds one 24-bit pixel. The transitions are as follows. Load-16 goes from `S_EMPTY` to `S_LO16`. Load-24 goes from `S_EMPTY` to `S_WORD24`. Step-half goes from `S_LO16` to `S_HI16`. Drain goes from `S_HI16` or `S_WORD24` to `S_EMPTY`. Drain-and-reload goes from `S_HI16` or `S_WORD24` directly to `S_LO16` or `S_WORD24` when a new word arrives in the draining cycle.

Top module: `pixel_unpacker`

## Requirements
- R1: After reset pix_valid and underflow are 0, and with a legal configuration word_ready is 1 and cfg_error is 0.
- R2: With word length code 0 (16-bit pixels) one word gives two RGB565 pixels: bits 15:0 first, then bits 31:16, each placed on pix_out[15:0].
- R3: With word length code 3 (24-bit pixels) one word gives one pixel on pix_out[23:0] with red = bits 23:16, green = bits 15:8 and blue = bits 7:0. Bits 31:24 are ignored whatever the mask.
- R4: With cfg_trunc18 = 1 and 24-bit pixels the output is {red[7:2], green[7:2], blue[7:2]} on pix_out[17:0]. With 16-bit pixels cfg_trunc18 has no effect.
- R5: A byte whose bit in cfg_byte_mask (bit n for word bits 8n+7:8n) is 0 is read as zero.
- R6: Bus width code 0 = 16, 1 = 8, 2 = 18 and 3 = 24 bits. pix_out bits at or above the bus width are always 0.
- R7: With 16-bit pixels on the 8-bit bus each pixel takes two requests: the first gives pixel bits 15:8 and the second gives bits 7:0.
- R8: Word length codes 1 and 2, and code 3 together with the 8-bit bus, set cfg_error and hold word_ready low.
- R9: word_ready is 1 only in S_EMPTY, or in S_HI16/S_WORD24 when that request consumes the last pixel; it is 0 while a lower half is pending.
- R10: A pix_req with no pixel pending gives underflow = 1 and pix_valid = 0 in the next cycle.
- R11: A pixel appears on pix_out with pix_valid = 1 in the cycle after its pix_req. Without a request, pix_valid is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Dot clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_word_len | input | 2 | Word length code (0 = 16-bit, 3 = 24-bit pixels) |
| cfg_byte_mask | input | 4 | Valid mask, one bit per word byte |
| cfg_trunc18 | input | 1 | Drop two LSBs of each 24-bit colour component |
| cfg_bus_width | input | 2 | Output bus code (0 = 16, 1 = 8, 2 = 18, 3 = 24) |
| word_valid | input | 1 | FIFO word available |
| word_data | input | 32 | FIFO word |
| word_ready | output | 1 | Word taken at this edge when valid |
| pix_req | input | 1 | Request for the next pixel or beat |
| pix_out | output | 24 | Formatted pixel data |
| pix_valid | output | 1 | pix_out holds a pixel delivered for the last request |
| underflow | output | 1 | Last request found no pixel pending |
| cfg_error | output | 1 | Configuration unsupported |

## Verification
The bench checks the half-word ordering. A design that emitted the upper RGB565 pixel first would swap every pair. It checks that a fresh word is refused while a lower half is still pending, and is accepted in the very cycle the last pixel drains. A wrong ready would either lose a pixel or stall the stream. It checks that the 18-bit reduction keeps the high component bits and not the low ones, that masked and top bytes come out as zero, and that narrow-bus beats come out high byte first. Empty requests must flag underflow without a stale valid, and unsupported word lengths must block intake instead of producing garbage.

// File: rtl/pxu_pkg.sv
package pxu_pkg;
    localparam int WORD_W  = 32;
    localparam int PIX_W   = 24;
    localparam int BYTES   = WORD_W / 8;
    localparam int HALF_W  = WORD_W / 2;

    localparam logic [1:0] WL_16  = 2'd0;
    localparam logic [1:0] WL_24  = 2'd3;

    localparam logic [1:0] BUS_16 = 2'd0;
    localparam logic [1:0] BUS_8  = 2'd1;
    localparam logic [1:0] BUS_18 = 2'd2;
    localparam logic [1:0] BUS_24 = 2'd3;

    typedef enum logic [1:0] {
        S_EMPTY  = 2'd0,
        S_LO16   = 2'd1,
        S_HI16   = 2'd2,
        S_WORD24 = 2'd3
    } pxu_state_e;

    function automatic logic [PIX_W-1:0] bus_keep(input logic [1:0] code);
        logic [PIX_W-1:0] k;
        unique case (code)
            BUS_8:   k = PIX_W'(24'h0000FF);
            BUS_16:  k = PIX_W'(24'h00FFFF);
            BUS_18:  k = PIX_W'(24'h03FFFF);
            default: k = PIX_W'(24'hFFFFFF);
        endcase
        return k;
    endfunction
endpackage

// File: rtl/pxu_cfg_check.sv
module pxu_cfg_check
    import pxu_pkg::*;
(
    input  logic [1:0] word_len,
    input  logic [1:0] bus_width,
    output logic       is16,
    output logic       narrow,
    output logic       cfg_ok
);
    logic is24;

    always_comb begin
        is16   = (word_len == WL_16);
        is24   = (word_len == WL_24);
        narrow = is16 && (bus_width == BUS_8);
        cfg_ok = is16 || (is24 && (bus_width != BUS_8));
    end
endmodule

// File: rtl/pxu_fsm.sv
module pxu_fsm
    import pxu_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_ok,
    input  logic              is16,
    input  logic              narrow,
    input  logic [BYTES-1:0]  byte_mask,
    input  logic              word_valid,
    input  logic [WORD_W-1:0] word_data,
    output logic              word_ready,
    input  logic              pix_req,
    output logic [WORD_W-1:0] held_word,
    output logic              sel_hi,
    output logic              byte_phase,
    output logic              have_pix
);
    pxu_state_e state, state_nx;
    logic [WORD_W-1:0] masked;
    logic advance, last, take;

    for (genvar b = 0; b < BYTES; b++) begin : g_mask
        assign masked[b*8 +: 8] = byte_mask[b] ? word_data[b*8 +: 8] : 8'h00;
    end

    always_comb begin
        have_pix   = (state != S_EMPTY);
        sel_hi     = (state == S_HI16);
        last       = (state == S_HI16) || (state == S_WORD24);
        advance    = pix_req && have_pix && (!narrow || byte_phase);
        word_ready = cfg_ok && ((state == S_EMPTY) || (last && advance));
        take       = word_ready && word_valid;
    end

    always_comb begin
        state_nx = state;
        unique case (state)
            S_EMPTY:  if (take) state_nx = is16 ? S_LO16 : S_WORD24;
            S_LO16:   if (advance) state_nx = S_HI16;
            S_HI16,
            S_WORD24: if (advance) state_nx = take ? (is16 ? S_LO16 : S_WORD24) : S_EMPTY;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state <= S_EMPTY;
        else        state <= state_nx;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            held_word  <= '0;
            byte_phase <= 1'b0;
        end else begin
            if (take) held_word <= masked;
            if (!narrow)                      byte_phase <= 1'b0;
            else if (pix_req && have_pix)     byte_phase <= ~byte_phase;
        end
    end

    assert_no_intake_on_bad_cfg_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !cfg_ok |-> !word_ready);
    assert_hold_while_low_half_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (state == S_LO16) |-> !word_ready);
    assert_low_then_high_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (state == S_LO16 && advance) |=> (state == S_HI16));
endmodule

// File: rtl/pxu_map.sv
module pxu_map
    import pxu_pkg::*;
(
    input  logic [WORD_W-1:0] held_word,
    input  logic              sel_hi,
    input  logic              is16,
    input  logic              narrow,
    input  logic              byte_phase,
    input  logic              trunc18,
    input  logic [1:0]        bus_width,
    output logic [PIX_W-1:0]  pixel
);
    logic [HALF_W-1:0] half;
    logic [PIX_W-1:0]  raw;

    always_comb begin
        half = sel_hi ? held_word[WORD_W-1:HALF_W] : held_word[HALF_W-1:0];
        if (is16) begin
            if (narrow) raw = {16'h0, (byte_phase ? half[7:0] : half[15:8])};
            else        raw = {8'h0, half};
        end else if (trunc18) begin
            raw = {6'h0, held_word[23:18], held_word[15:10], held_word[7:2]};
        end else begin
            raw = held_word[PIX_W-1:0];
        end
        pixel = raw & bus_keep(bus_width);
    end
endmodule

// File: rtl/pixel_unpacker.sv
module pixel_unpacker
    import pxu_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [1:0]        cfg_word_len,
    input  logic [BYTES-1:0]  cfg_byte_mask,
    input  logic              cfg_trunc18,
    input  logic [1:0]        cfg_bus_width,
    input  logic              word_valid,
    input  logic [WORD_W-1:0] word_data,
    output logic              word_ready,
    input  logic              pix_req,
    output logic [PIX_W-1:0]  pix_out,
    output logic              pix_valid,
    output logic              underflow,
    output logic              cfg_error
);
    logic is16, narrow, cfg_ok, sel_hi, byte_phase, have_pix;
    logic [WORD_W-1:0] held_word;
    logic [PIX_W-1:0]  pixel;

    pxu_cfg_check u_cfg (
        .word_len  (cfg_word_len),
        .bus_width (cfg_bus_width),
        .is16      (is16),
        .narrow    (narrow),
        .cfg_ok    (cfg_ok)
    );

    pxu_fsm u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .cfg_ok     (cfg_ok),
        .is16       (is16),
        .narrow     (narrow),
        .byte_mask  (cfg_byte_mask),
        .word_valid (word_valid),
        .word_data  (word_data),
        .word_ready (word_ready),
        .pix_req    (pix_req),
        .held_word  (held_word),
        .sel_hi     (sel_hi),
        .byte_phase (byte_phase),
        .have_pix   (have_pix)
    );

    pxu_map u_map (
        .held_word  (held_word),
        .sel_hi     (sel_hi),
        .is16       (is16),
        .narrow     (narrow),
        .byte_phase (byte_phase),
        .trunc18    (cfg_trunc18),
        .bus_width  (cfg_bus_width),
        .pixel      (pixel)
    );

    assign cfg_error = !cfg_ok;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pix_out   <= '0;
            pix_valid <= 1'b0;
            underflow <= 1'b0;
        end else begin
            pix_valid <= pix_req && have_pix;
            underflow <= pix_req && !have_pix;
            if (pix_req && have_pix) pix_out <= pixel;
        end
    end

    assert_underflow_excludes_valid_R10: assert property (@(posedge clk) disable iff (!rst_n)
        underflow |-> !pix_valid);
    assert_valid_needs_request_R11: assert property (@(posedge clk) disable iff (!rst_n)
        pix_valid |-> $past(pix_req));
    assert_narrow_bus_clear_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (pix_valid && $past(cfg_bus_width) == BUS_8) |-> (pix_out[PIX_W-1:8] == '0));
endmodule

// File: tb/pixel_unpacker_tb.sv
module pixel_unpacker_tb;
    typedef struct packed {
        logic [1:0]        wl;
        logic [3:0]        mask;
        logic              trunc;
        logic [1:0]        bus;
        logic [31:0]       word;
        logic [2:0]        npx;
        logic [3:0][23:0]  exp;
        logic [3:0]        rid;
    } vec_t;

    localparam int NV = 10;
    localparam vec_t VECS [NV] = '{
        '{2'd0, 4'hF, 1'b0, 2'd0, 32'hABCD1234, 3'd2, {24'h0, 24'h0, 24'h00ABCD, 24'h001234}, 4'd2},
        '{2'd0, 4'hF, 1'b1, 2'd3, 32'hF80007E0, 3'd2, {24'h0, 24'h0, 24'h00F800, 24'h0007E0}, 4'd4},
        '{2'd3, 4'h7, 1'b0, 2'd3, 32'hFF123456, 3'd1, {24'h0, 24'h0, 24'h0, 24'h123456}, 4'd3},
        '{2'd3, 4'hF, 1'b0, 2'd3, 32'hAB123456, 3'd1, {24'h0, 24'h0, 24'h0, 24'h123456}, 4'd3},
        '{2'd3, 4'h7, 1'b1, 2'd2, 32'h00FF8040, 3'd1, {24'h0, 24'h0, 24'h0, 24'h03F810}, 4'd4},
        '{2'd3, 4'h7, 1'b0, 2'd0, 32'h00ABCDEF, 3'd1, {24'h0, 24'h0, 24'h0, 24'h00CDEF}, 4'd6},
        '{2'd3, 4'h5, 1'b0, 2'd3, 32'h11223344, 3'd1, {24'h0, 24'h0, 24'h0, 24'h220044}, 4'd5},
        '{2'd0, 4'hF, 1'b0, 2'd1, 32'hBEEF1234, 3'd4, {24'h0000EF, 24'h0000BE, 24'h000034, 24'h000012}, 4'd7},
        '{2'd0, 4'h3, 1'b0, 2'd0, 32'h55667788, 3'd2, {24'h0, 24'h0, 24'h000000, 24'h007788}, 4'd5},
        '{2'd3, 4'h7, 1'b0, 2'd2, 32'h00FFFFFF, 3'd1, {24'h0, 24'h0, 24'h0, 24'h03FFFF}, 4'd6}
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [1:0]  cfg_word_len = 2'd0;
    logic [3:0]  cfg_byte_mask = 4'hF;
    logic        cfg_trunc18 = 1'b0;
    logic [1:0]  cfg_bus_width = 2'd0;
    logic        word_valid = 1'b0;
    logic [31:0] word_data = '0;
    logic        word_ready;
    logic        pix_req = 1'b0;
    logic [23:0] pix_out;
    logic        pix_valid;
    logic        underflow;
    logic        cfg_error;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #5 clk = ~clk;

    pixel_unpacker u_dut (
        .clk           (clk),
        .rst_n         (rst_n),
        .cfg_word_len  (cfg_word_len),
        .cfg_byte_mask (cfg_byte_mask),
        .cfg_trunc18   (cfg_trunc18),
        .cfg_bus_width (cfg_bus_width),
        .word_valid    (word_valid),
        .word_data     (word_data),
        .word_ready    (word_ready),
        .pix_req       (pix_req),
        .pix_out       (pix_out),
        .pix_valid     (pix_valid),
        .underflow     (underflow),
        .cfg_error     (cfg_error)
    );

    function automatic string tag(input logic [3:0] id);
        case (id)
            4'd2: return "R2";
            4'd3: return "R3";
            4'd4: return "R4";
            4'd5: return "R5";
            4'd6: return "R6";
            default: return "R7";
        endcase
    endfunction

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic summary();
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    endtask

    task automatic set_cfg(input logic [1:0] wl, input logic [3:0] m, input logic t, input logic [1:0] b);
        cfg_word_len  = wl;
        cfg_byte_mask = m;
        cfg_trunc18   = t;
        cfg_bus_width = b;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            summary();
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: reset state
        chk("R1", pix_valid, 0);
        chk("R1", underflow, 0);
        chk("R1", word_ready, 1);
        chk("R1", cfg_error, 0);

        // Vector table: one word per entry, pixels streamed back to back
        for (int v = 0; v < NV; v++) begin
            set_cfg(VECS[v].wl, VECS[v].mask, VECS[v].trunc, VECS[v].bus);
            word_valid = 1'b1;
            word_data  = VECS[v].word;
            #1;
            chk("R9", word_ready, 1);
            @(negedge clk);
            word_valid = 1'b0;
            pix_req    = 1'b1;
            for (int p = 0; p < int'(VECS[v].npx); p++) begin
                @(negedge clk);
                chk("R11", pix_valid, 1);
                chk(tag(VECS[v].rid), pix_out, VECS[v].exp[p]);
            end
            pix_req = 1'b0;
            @(negedge clk);
            chk("R11", pix_valid, 0);
            chk("R9", word_ready, 1);
        end

        // R10: request while empty
        set_cfg(2'd3, 4'h7, 1'b0, 2'd3);
        pix_req = 1'b1;
        @(negedge clk);
        pix_req = 1'b0;
        chk("R10", underflow, 1);
        chk("R10", pix_valid, 0);
        @(negedge clk);
        chk("R10", underflow, 0);

        // R9: drain and reload in the same cycle, 24-bit words
        word_valid = 1'b1;
        word_data  = 32'h00111111;
        @(negedge clk);
        word_data = 32'h00222222;
        pix_req   = 1'b1;
        #1;
        chk("R9", word_ready, 1);
        @(negedge clk);
        word_valid = 1'b0;
        chk("R9", pix_out, 32'h111111);
        @(negedge clk);
        chk("R9", pix_out, 32'h222222);
        pix_req = 1'b0;
        @(negedge clk);

        // R9: refuse while lower half is pending
        set_cfg(2'd0, 4'hF, 1'b0, 2'd0);
        word_valid = 1'b1;
        word_data  = 32'hAAAA5555;
        @(negedge clk);
        word_data = 32'h77778888;
        #1;
        chk("R9", word_ready, 0);
        word_valid = 1'b0;
        pix_req = 1'b1;
        @(negedge clk);
        chk("R2", pix_out, 32'h5555);
        @(negedge clk);
        chk("R2", pix_out, 32'hAAAA);
        pix_req = 1'b0;
        @(negedge clk);

        // R8: unsupported configurations
        set_cfg(2'd1, 4'hF, 1'b0, 2'd0);
        #1;
        chk("R8", cfg_error, 1);
        chk("R8", word_ready, 0);
        set_cfg(2'd2, 4'hF, 1'b0, 2'd3);
        #1;
        chk("R8", cfg_error, 1);
        set_cfg(2'd3, 4'h7, 1'b0, 2'd1);
        #1;
        chk("R8", cfg_error, 1);
        chk("R8", word_ready, 0);
        set_cfg(2'd3, 4'h7, 1'b0, 2'd3);
        #1;
        chk("R8", cfg_error, 0);

        done = 1'b1;
        summary();
        $finish;
    end
endmodule